// File: doc/BRIEF.md
# Sleep Entry and Exit Controller

This block sits between a synchronous memory's access-control inputs and its core. It accepts an asynchronous, active-high sleep request. It brings that request into the clock domain, then steps through a short, fixed sequence that places the memory in a low-power state where the stored contents are kept.

Coming back out takes the same number of cycles. A recovery window follows, and for its whole length the chip enable and both address strobes must stay idle. While the block is in any non-awake state, it masks those three active-low controls before they reach the core, and it tells the data path to hold its outputs at high impedance.

Any attempt to start an access while the memory is going to sleep, asleep, waking or recovering is recorded in a sticky error flag. Only reset clears the flag.

Top module: `nap_ctrl`

## Requirements
- R1: Immediately after reset, sleep_active, access_block and protocol_error are 0 and the three core outputs follow their inputs.
- R2: The request passes through two flops. access_block rises on the third rising edge that samples the request high, counting the first.
- R3: The entry phase lasts TRANS_CYCLES (2) cycles, so sleep_active rises two edges after access_block. Entry always completes, even when the request drops during it.
- R4: Once the synchronized request is seen low while asleep, sleep_active falls on that edge. Exit then lasts 2 cycles, followed by RECOVER_CYCLES (default 3) recovery cycles. access_block then returns to 0.
- R5: While access_block is 1, core_cs_n, core_strb_p_n and core_strb_c_n are forced to 1. Otherwise each equals its input. All three controls are active-low.
- R6: Any of cs_n, strb_p_n or strb_c_n sampled low while access_block is 1 sets protocol_error on that edge. This includes the last recovery cycle.
- R7: protocol_error stays 1 until reset and is unaffected by later idle cycles or wake-ups.
- R8: Controls driven low while access_block is 0 never set protocol_error. This includes the first cycle after recovery ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| nap_req | input | 1 | Asynchronous sleep request, active high |
| cs_n | input | 1 | Chip enable from the host, active low |
| strb_p_n | input | 1 | First address strobe, active low |
| strb_c_n | input | 1 | Second address strobe, active low |
| core_cs_n | output | 1 | Gated chip enable to the core |
| core_strb_p_n | output | 1 | Gated first strobe to the core |
| core_strb_c_n | output | 1 | Gated second strobe to the core |
| sleep_active | output | 1 | Memory is in the low-power state |
| access_block | output | 1 | Accesses masked, data outputs held at high impedance |
| protocol_error | output | 1 | Sticky flag for a control asserted while blocked |

## Verification
Two functions can land in the same cycle. One is the boundary between the end of recovery and the return to awake operation. The other is error capture together with strobe masking on that same edge.

The bench drives a strobe low in the very last recovery cycle and expects two things: the strobe is masked, and the error sets on the next edge. It then repeats the exercise one cycle later, where the same strobe must pass to the core and leave the flag clear.

A one-cycle request pulse that drops during entry is also judged. The bench compares the exact cycle-by-cycle shape of sleep_active and access_block against the sequence lengths.

// File: rtl/nap_ctrl.sv
module nap_ctrl #(
  parameter int TRANS_CYCLES   = 2,
  parameter int RECOVER_CYCLES = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic nap_req,
  input  logic cs_n,
  input  logic strb_p_n,
  input  logic strb_c_n,
  output logic core_cs_n,
  output logic core_strb_p_n,
  output logic core_strb_c_n,
  output logic sleep_active,
  output logic access_block,
  output logic protocol_error
);
  localparam int CNT_MAX = (RECOVER_CYCLES > TRANS_CYCLES) ? RECOVER_CYCLES : TRANS_CYCLES;
  localparam int CW      = $clog2(CNT_MAX + 1);

  typedef enum logic [2:0] {AWAKE, ENTERING, ASLEEP, EXITING, RECOVERY} state_t;

  state_t          st, st_nxt;
  logic [CW-1:0]   cnt, cnt_nxt;
  logic [1:0]      sync_q;
  logic            req_s;
  logic            misuse;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[0], nap_req};

  assign req_s = sync_q[1];

  always_comb begin
    st_nxt  = st;
    cnt_nxt = cnt;
    case (st)
      AWAKE:    if (req_s) begin st_nxt = ENTERING; cnt_nxt = CW'(TRANS_CYCLES - 1); end
      ENTERING: if (cnt == '0) st_nxt = ASLEEP; else cnt_nxt = cnt - 1'b1;
      ASLEEP:   if (!req_s) begin st_nxt = EXITING; cnt_nxt = CW'(TRANS_CYCLES - 1); end
      EXITING:  if (cnt == '0) begin st_nxt = RECOVERY; cnt_nxt = CW'(RECOVER_CYCLES - 1); end
                else cnt_nxt = cnt - 1'b1;
      RECOVERY: if (cnt == '0) st_nxt = AWAKE; else cnt_nxt = cnt - 1'b1;
      default:  st_nxt = AWAKE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st  <= AWAKE;
      cnt <= '0;
    end else begin
      st  <= st_nxt;
      cnt <= cnt_nxt;
    end

  assign access_block = (st != AWAKE);
  assign sleep_active = (st == ASLEEP);
  assign misuse       = access_block & ~(cs_n & strb_p_n & strb_c_n);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) protocol_error <= 1'b0;
    else        protocol_error <= protocol_error | misuse;

  assign core_cs_n     = cs_n     | access_block;
  assign core_strb_p_n = strb_p_n | access_block;
  assign core_strb_c_n = strb_c_n | access_block;

  assert_entry_after_sync_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(access_block) |-> $past(req_s));

  assert_entry_length_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sleep_active) |-> ($past(access_block) && $past(access_block, 2)));

  assert_exit_still_blocked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sleep_active) |-> access_block);

  assert_sleep_implies_block_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_active |-> (access_block && core_cs_n && core_strb_p_n && core_strb_c_n));

  assert_misuse_flagged_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (access_block && !strb_c_n) |=> protocol_error);

  assert_error_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    protocol_error |=> protocol_error);
endmodule

// File: tb/tb_nap_ctrl.sv
module tb_nap_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic nap_req = 1'b0, cs_n = 1'b1, strb_p_n = 1'b1, strb_c_n = 1'b1;
  logic core_cs_n, core_strb_p_n, core_strb_c_n;
  logic sleep_active, access_block, protocol_error;
  int   n_chk = 0, n_bad = 0;
  bit   done = 1'b0;

  always #4 clk = ~clk;

  nap_ctrl dut (
    .clk(clk), .rst_n(rst_n), .nap_req(nap_req), .cs_n(cs_n),
    .strb_p_n(strb_p_n), .strb_c_n(strb_c_n),
    .core_cs_n(core_cs_n), .core_strb_p_n(core_strb_p_n), .core_strb_c_n(core_strb_c_n),
    .sleep_active(sleep_active), .access_block(access_block), .protocol_error(protocol_error)
  );

  // stim {req, cs_n, strb_p_n, strb_c_n}, expect {sleep, block, err, core_cs_n, core_p_n, core_c_n}
  localparam logic [9:0] VEC [0:17] = '{
    10'b0111_000111, 10'b0001_000001, 10'b1111_000111, 10'b1010_000010,
    10'b1111_000111, 10'b1111_010111, 10'b1111_010111, 10'b1111_110111,
    10'b0111_110111, 10'b0111_110111, 10'b0111_110111, 10'b0111_010111,
    10'b0111_010111, 10'b0111_010111, 10'b0111_010111, 10'b0111_010111,
    10'b0111_000111, 10'b0000_000000
  };

  function automatic logic [5:0] outs();
    return {sleep_active, access_block, protocol_error, core_cs_n, core_strb_p_n, core_strb_c_n};
  endfunction

  task automatic cyc(input logic [3:0] s);
    @(negedge clk);
    {nap_req, cs_n, strb_p_n, strb_c_n} = s;
    #2;
  endtask

  task automatic chk(input string req, input logic [5:0] exp);
    n_chk++;
    if (outs() !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", req, outs(), exp);
    end
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R1 through R5, R8: table walk
    foreach (VEC[i]) begin
      cyc(VEC[i][9:6]);
      chk($sformatf("R1/R2/R3/R4/R5 vector %0d", i), VEC[i][5:0]);
    end
    // R3 R4 R8: one-cycle pulse, exact shape, access just after recovery
    for (int i = 0; i < 13; i++) begin
      logic [5:0] e;
      logic       blk;
      blk = (i >= 3 && i <= 10);
      cyc(i == 0 ? 4'b1111 : (i == 11 ? 4'b0000 : 4'b0111));
      e = {i == 5, blk, 1'b0, (i == 11 && !blk) ? 3'b000 : 3'b111};
      chk($sformatf("R3/R4/R8 pulse step %0d", i), e);
    end
    // R6 R5: strobe in final recovery cycle is masked and flagged
    for (int i = 0; i < 12; i++) begin
      logic [5:0] e;
      cyc(i == 0 ? 4'b1111 : (i == 10 ? 4'b0110 : 4'b0111));
      e = {i == 5, (i >= 3 && i <= 10), i == 11, 3'b111};
      chk($sformatf("R6/R5 last-recovery step %0d", i), e);
    end
    // R7: flag stays through idle cycles
    for (int i = 0; i < 3; i++) begin
      cyc(4'b0111);
      chk("R7 sticky while idle", 6'b001111);
    end
    // R1: reset clears everything
    @(negedge clk) rst_n = 1'b0;
    #2 chk("R1 reset clears flag", 6'b000111);
    @(negedge clk) rst_n = 1'b1;
    // R6 R7: chip enable while asleep, then wake
    for (int i = 0; i < 6; i++) cyc(4'b1111);
    chk("R3 asleep with request held", 6'b110111);
    cyc(4'b1011);
    chk("R5 cs masked while asleep", 6'b110111);
    cyc(4'b1111);
    chk("R6 cs while asleep flagged", 6'b111111);
    for (int i = 0; i < 10; i++) cyc(4'b0111);
    chk("R7 flag survives wake-up", 6'b001111);
    done = 1'b1;
    finish_run();
  end
endmodule